// File: doc/BRIEF.md
# Serial Receiver with Line Status

This block turns an asynchronous serial line into characters and places them in a receive queue. A sample enable arrives at sixteen times the bit rate. The receiver looks for a falling edge on the line and confirms the start bit at its centre. It then shifts in five to eight data bits, least significant bit first. An optional parity bit follows, then the stop bit. Each finished character is stored together with three tags: parity error, framing error and break. With the queue enabled it holds sixteen characters. With the queue disabled it behaves as a single holding register.

A CPU reads two locations. Reading the data location pops the character at the head of the queue. Reading the status location returns an eight-bit line status word and clears the sticky error bits. Error tags stay hidden while their character waits behind others. They appear in the status word only once that character is at the head. The two transmitter bits in the status word are registered copies of inputs supplied by a separate transmitter.

Top module: `serial_rx_status`

## Requirements
- R1: The status word is {bit7 error-in-queue, bit6 transmitter empty, bit5 transmitter ready, bit4 break, bit3 framing error, bit2 parity error, bit1 overrun, bit0 data available}. In reset it reads 8'h60. Bits 5 and 6 follow `tx_ready_i` and `tx_empty_i` one clock later.
- R2: Bit 0 is 1 while at least one character is stored. It returns to 0 once every stored character has been popped through `rd_data_i`.
- R3: A low level seen at a sample tick is checked again 8 ticks later. If the line is high then, the start is discarded and nothing is stored.
- R4: `len_i` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The bits are received least significant first. `rdata_o` shows the head character zero-extended, or 0 when nothing is stored.
- R5: With `par_en_i` set, a parity bit follows the data. `par_even_i`=1 selects even parity and 0 selects odd parity. A mismatch tags the character with a parity error.
- R6: A stop bit sampled as 0 tags the character with a framing error.
- R7: Bits 2, 3 and 4 are set from a character's tags one clock after that character becomes the head. Tags on characters queued behind the head do not show.
- R8: After a framing error that is not a break, the bit period after the stop bit is sampled. A 0 is taken as a confirmed start bit and the next character is shifted in. A 1 returns the receiver to idle.
- R9: A frame whose data, parity and stop bits are all 0 stores a single zero character tagged break and framing error. The receiver then waits for the line to go high before it hunts for a start bit.
- R10: Capacity is 16 characters with `fifo_en_i`=1 and 1 character with `fifo_en_i`=0. A character completed while the store is full is dropped, the stored data is unchanged, and bit 1 is set.
- R11: A `rd_stat_i` strobe clears bits 1 to 4 at the next clock edge.
- R12: Bit 7 is set when a tagged character is stored. It is cleared by a `rd_stat_i` strobe only when no tagged character remains stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | Sample enable at OSR times the bit rate |
| len_i | input | 2 | Data length select (5 + value bits) |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | 1 even parity, 0 odd parity |
| fifo_en_i | input | 1 | 1 selects the 16-entry queue, 0 a single holding register |
| rd_data_i | input | 1 | Data read strobe, pops the head character |
| rd_stat_i | input | 1 | Status read strobe, clears the sticky error bits |
| tx_ready_i | input | 1 | Transmitter ready flag from the transmitter |
| tx_empty_i | input | 1 | Transmitter empty flag from the transmitter |
| rdata_o | output | 8 | Head character, zero-extended |
| status_o | output | 8 | Line status word |

## Verification
The bench uses the default DEPTH of 16 and OSR of 16, with a sample tick on every second clock, so each bit lasts 32 clocks. With OSR at 16 the start check falls 8 ticks after the edge. A three-tick low pulse is therefore rejected, and a frame whose stop bit is followed directly by the next start bit exercises the resynchronisation path. At DEPTH 16, seventeen back-to-back frames with no reads are enough to reach the full queue and the dropped character that follows.

// File: rtl/serial_rx_status.sv
module serial_rx_status #(
  parameter int DEPTH = 16,
  parameter int OSR   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  input  logic       tick_i,
  input  logic [1:0] len_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       fifo_en_i,
  input  logic       rd_data_i,
  input  logic       rd_stat_i,
  input  logic       tx_ready_i,
  input  logic       tx_empty_i,
  output logic [7:0] rdata_o,
  output logic [7:0] status_o
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int TW  = $clog2(OSR);
  localparam int MID = OSR / 2 - 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_SYNC, S_HOLD} st_t;

  st_t             st;
  logic [TW-1:0]   tcnt;
  logic [2:0]      bcnt;
  logic [7:0]      sh;
  logic            pbit;
  logic [10:0]     mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [CW-1:0]   cnt, tag_cnt;
  logic            oe_q, pe_q, fe_q, bi_q, err_q, txr_q, txe_q, hrep;

  wire       bit_end  = tick_i && tcnt == TW'(OSR - 1);
  wire [7:0] dat      = sh >> (2'd3 - len_i);
  wire       perr     = par_en_i && (^dat ^ pbit ^ ~par_even_i);
  wire       brk      = dat == 8'd0 && !(par_en_i && pbit) && !rx_i;
  wire       done     = st == S_STOP && bit_end;
  wire       in_tag   = perr || !rx_i || brk;
  wire       full     = cnt >= (fifo_en_i ? CW'(DEPTH) : CW'(1));
  wire       push     = done && !full;
  wire       pop      = rd_data_i && cnt != '0;
  wire [10:0] head    = mem[rp];
  wire       h_tag    = |head[10:8];
  wire       report   = cnt != '0 && !hrep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tcnt <= '0; bcnt <= '0; sh <= '0; pbit <= 1'b0;
    end else if (tick_i) begin
      tcnt <= tcnt + 1'b1;
      case (st)
        S_IDLE:  if (!rx_i) begin st <= S_START; tcnt <= '0; end
        S_START: if (tcnt == TW'(MID)) begin
                   tcnt <= '0; bcnt <= '0;
                   st <= rx_i ? S_IDLE : S_DATA;
                 end
        S_DATA:  if (bit_end) begin
                   sh <= {rx_i, sh[7:1]};
                   bcnt <= bcnt + 1'b1;
                   if (bcnt == {1'b1, len_i}) st <= par_en_i ? S_PAR : S_STOP;
                 end
        S_PAR:   if (bit_end) begin pbit <= rx_i; st <= S_STOP; end
        S_STOP:  if (bit_end) st <= rx_i ? S_IDLE : (brk ? S_HOLD : S_SYNC);
        S_SYNC:  if (bit_end) begin bcnt <= '0; st <= rx_i ? S_IDLE : S_DATA; end
        S_HOLD:  if (rx_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) if (push) mem[wp] <= {brk, !rx_i, perr, dat};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; tag_cnt <= '0;
      oe_q <= 1'b0; pe_q <= 1'b0; fe_q <= 1'b0; bi_q <= 1'b0; err_q <= 1'b0;
      txr_q <= 1'b1; txe_q <= 1'b1; hrep <= 1'b0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt     <= cnt + CW'(push) - CW'(pop);
      tag_cnt <= tag_cnt + CW'(push && in_tag) - CW'(pop && h_tag);
      oe_q  <= (oe_q && !rd_stat_i) || (done && full);
      pe_q  <= (pe_q && !rd_stat_i) || (report && head[8]);
      fe_q  <= (fe_q && !rd_stat_i) || (report && head[9]);
      bi_q  <= (bi_q && !rd_stat_i) || (report && head[10]);
      err_q <= (err_q && !(rd_stat_i && tag_cnt == '0)) || (push && in_tag);
      hrep  <= pop ? 1'b0 : cnt != '0;
      txr_q <= tx_ready_i;
      txe_q <= tx_empty_i;
    end
  end

  assign rdata_o  = (cnt != '0) ? head[7:0] : 8'd0;
  assign status_o = {err_q, txe_q, txr_q, bi_q, fe_q, pe_q, oe_q, cnt != '0};
endmodule

// File: rtl/serial_rx_status_chk.sv
module serial_rx_status_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_data_i,
  input logic          tx_ready_i,
  input logic [7:0]    status_o,
  input logic          done,
  input logic          full,
  input logic          pop,
  input logic [CW-1:0] cnt
);
  p_dr_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[0]) |-> $past(rd_data_i));
  p_drop_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full && !pop) |=> $stable(cnt));
  p_ovr_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[1]) |-> $past(done && full));
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_pe_at_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[2]) |-> $past(status_o[0]));
  p_tx_copy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> status_o[5] == $past(tx_ready_i));
endmodule

bind serial_rx_status serial_rx_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data_i(rd_data_i), .tx_ready_i(tx_ready_i),
  .status_o(status_o), .done(done), .full(full), .pop(pop), .cnt(cnt)
);

// File: tb/test_serial_rx_status.sv
module test_serial_rx_status;
  localparam int OSR = 16;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, tick = 1'b0;
  logic [1:0] len = 2'd3;
  logic par_en = 1'b0, par_even = 1'b1, fifo_en = 1'b1;
  logic rd_data = 1'b0, rd_stat = 1'b0, tx_ready = 1'b0, tx_empty = 1'b0;
  logic [7:0] rdata, status;

  serial_rx_status #(.DEPTH(DEPTH), .OSR(OSR)) i_serial_rx_status (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick), .len_i(len),
    .par_en_i(par_en), .par_even_i(par_even), .fifo_en_i(fifo_en),
    .rd_data_i(rd_data), .rd_stat_i(rd_stat), .tx_ready_i(tx_ready),
    .tx_empty_i(tx_empty), .rdata_o(rdata), .status_o(status));

  always #5 clk = ~clk;
  always @(posedge clk) tick <= ~tick;

  typedef struct { logic [7:0] d; bit pe; bit fe; bit bi; } ent_t;
  ent_t q[$];
  ent_t pend;
  bit push_pend = 0, insync = 0, finished = 0;
  bit m_oe, m_pe, m_fe, m_bi, m_err, m_txr = 1, m_txe = 1, m_rep;
  int errors = 0, checks = 0;

  function automatic string req_of(int b);
    case (b)
      0: return "R2"; 1: return "R10"; 2: return "R5/R7"; 3: return "R6";
      4: return "R9"; 5, 6: return "R1"; 7: return "R12"; default: return "R4";
    endcase
  endfunction

  always @(posedge clk) begin : model
    int n, tc, cap;
    bit npe, nfe, nbi, popn, acc, tg;
    if (!rst_n) begin
      q.delete(); push_pend = 0;
      {m_oe, m_pe, m_fe, m_bi, m_err, m_rep} = '0;
      m_txr = 1; m_txe = 1;
    end else begin
      n = q.size(); tc = 0;
      foreach (q[i]) if (q[i].pe || q[i].fe || q[i].bi) tc++;
      cap = fifo_en ? DEPTH : 1;
      {npe, nfe, nbi} = '0;
      if (n > 0 && !m_rep) begin npe = q[0].pe; nfe = q[0].fe; nbi = q[0].bi; end
      popn = rd_data && n > 0;
      acc = push_pend && n < cap;
      tg = pend.pe || pend.fe || pend.bi;
      m_oe  = (m_oe && !rd_stat) || (push_pend && n >= cap);
      m_pe  = (m_pe && !rd_stat) || npe;
      m_fe  = (m_fe && !rd_stat) || nfe;
      m_bi  = (m_bi && !rd_stat) || nbi;
      m_err = (m_err && !(rd_stat && tc == 0)) || (acc && tg);
      m_rep = popn ? 0 : (n > 0);
      if (popn) void'(q.pop_front());
      if (acc) q.push_back(pend);
      push_pend = 0;
      m_txr = tx_ready; m_txe = tx_empty;
    end
  end

  always @(negedge clk) begin : compare
    logic [7:0] es, ed;
    if (rst_n && insync && !finished) begin
      es = {m_err, m_txe, m_txr, m_bi, m_fe, m_pe, m_oe, q.size() > 0};
      ed = (q.size() > 0) ? q[0].d : 8'd0;
      checks++;
      if (es !== status || ed !== rdata) begin
        errors++;
        for (int b = 0; b < 9; b++)
          if (b == 8 ? (ed !== rdata) : (es[b] !== status[b])) begin
            $display("FAIL %s per-clock: status=%h rdata=%h expected status=%h rdata=%h",
                     req_of(b), status, rdata, es, ed);
            break;
          end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_wait();
    repeat (2 * OSR) @(negedge clk);
  endtask

  task automatic idle(input int n);
    rx = 1'b1;
    repeat (4) @(negedge clk);
    insync = 1;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad, input bit stp);
    int nb;
    logic [7:0] m;
    bit pb;
    nb = 5 + len;
    m = d & 8'((1 << nb) - 1);
    pb = (^m) ^ ~par_even ^ bad;
    insync = 0;
    rx = 1'b0; bit_wait();
    for (int i = 0; i < nb; i++) begin rx = m[i]; bit_wait(); end
    if (par_en) begin rx = pb; bit_wait(); end
    rx = stp; bit_wait();
    pend.d = m; pend.pe = par_en && bad; pend.fe = !stp;
    pend.bi = (m == 0) && (!par_en || !pb) && !stp;
    push_pend = 1;
  endtask

  task automatic send_break(input int nbit);
    insync = 0;
    rx = 1'b0;
    repeat (nbit) bit_wait();
    pend.d = 8'd0; pend.pe = par_en && !par_even; pend.fe = 1; pend.bi = 1;
    push_pend = 1;
  endtask

  task automatic rd_dat();
    @(negedge clk) rd_data = 1'b1;
    @(negedge clk) rd_data = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_st();
    @(negedge clk) rd_stat = 1'b1;
    @(negedge clk) rd_stat = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(status == 8'h60, "R1 reset value", status, 8'h60);
    chk(rdata == 8'h00, "R4 empty read data", rdata, 0);
    rst_n = 1'b1;
    tx_ready = 1'b1; tx_empty = 1'b1;
    idle(4);
    tx_ready = 1'b0;
    repeat (2) @(negedge clk);
    chk(status[5] == 1'b0, "R1 tx ready copy", status[5], 0);
    tx_ready = 1'b1;
    repeat (2) @(negedge clk);

    send_frame(8'hA5, 0, 1); idle(4);
    chk(status[0] == 1'b1, "R2 data available", status[0], 1);
    chk(rdata == 8'hA5, "R4 eight bits", rdata, 8'hA5);
    rd_dat();
    chk(status[0] == 1'b0, "R2 cleared after read", status[0], 0);

    len = 2'd0;
    send_frame(8'h3B, 0, 1); idle(4);
    chk(rdata == 8'h1B, "R4 five bits", rdata, 8'h1B);
    rd_dat();
    len = 2'd3;

    insync = 0;
    rx = 1'b0; repeat (6) @(negedge clk);
    idle(80);
    chk(status[0] == 1'b0, "R3 false start rejected", status[0], 0);

    par_en = 1'b1; par_even = 1'b1;
    send_frame(8'h01, 0, 1);
    send_frame(8'h03, 1, 1); idle(4);
    chk(status[2] == 1'b0, "R7 tag hidden behind head", status[2], 0);
    chk(status[7] == 1'b1, "R12 tagged entry stored", status[7], 1);
    rd_dat();
    chk(status[2] == 1'b1, "R5 parity error at head", status[2], 1);
    rd_st();
    chk(status[2] == 1'b0, "R11 status read clears", status[2], 0);
    chk(status[7] == 1'b1, "R12 kept while tagged entry stored", status[7], 1);
    rd_dat();
    chk(status[7] == 1'b1, "R12 kept until status read", status[7], 1);
    rd_st();
    chk(status[7] == 1'b0, "R12 cleared", status[7], 0);

    par_even = 1'b0;
    send_frame(8'h07, 0, 1); idle(4);
    rd_dat();
    chk(status[2] == 1'b0, "R5 odd parity accepted", status[2], 0);
    par_en = 1'b0;

    send_frame(8'h55, 0, 0); idle(40);
    chk(status[3] == 1'b1, "R6 framing error", status[3], 1);
    rd_dat();
    chk(status[0] == 1'b0, "R8 idle after stop error", status[0], 0);
    rd_st();

    send_frame(8'h12, 0, 0);
    send_frame(8'h34, 0, 1); idle(4);
    chk(rdata == 8'h12, "R8 first of pair", rdata, 8'h12);
    rd_dat();
    chk(rdata == 8'h34, "R8 resync character", rdata, 8'h34);
    rd_dat(); rd_st();

    send_break(25); idle(4);
    chk(status[4:3] == 2'b11, "R9 break and framing", status[4:3], 3);
    chk(rdata == 8'h00, "R9 zero character", rdata, 0);
    rd_dat();
    chk(status[0] == 1'b0, "R9 single entry", status[0], 0);
    rd_st();

    for (int i = 0; i < DEPTH + 1; i++) send_frame(8'(i + 8'h40), 0, 1);
    idle(4);
    chk(status[1] == 1'b1, "R10 overrun queue", status[1], 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk(rdata == 8'(i + 8'h40), "R10 stored data kept", rdata, i + 8'h40);
      rd_dat();
    end
    chk(status[0] == 1'b0, "R10 sixteen stored", status[0], 0);
    rd_st();
    chk(status[1] == 1'b0, "R11 overrun cleared", status[1], 0);

    fifo_en = 1'b0;
    send_frame(8'h61, 0, 1);
    send_frame(8'h62, 0, 1); idle(4);
    chk(status[1] == 1'b1, "R10 overrun holding", status[1], 1);
    chk(rdata == 8'h61, "R10 holding kept", rdata, 8'h61);
    rd_dat(); rd_st();

    finish_run();
  end
endmodule